// File: doc/BRIEF.md
# Register File Address Translator

This block turns a register operand taken from a decoded instruction into an absolute address in an 8-bit-addressed register file. Each address splits into a high nibble, which picks one of sixteen 16-register groups, and a low nibble, which picks a register in that group. Groups 0 to D are general purpose, group E holds the system registers and group F is a paged window. The block keeps two register-pointer registers and one page-pointer register, and it updates them when the decoder issues a set-pointer command.

A working-register operand is a 4-bit number. It is added to one pointer base in single-window mode, which gives one 16-register window. In twin-window mode it goes to one of two pointer bases, which gives two 8-register windows. A direct operand is an 8-bit address. A direct address in group F is qualified with the current page. A direct address in group D is treated as a working-register reference, because group D may only be reached through the pointers. The physical address is 14 bits wide, `{page[5:0], reg[7:0]}`, and comes with a page-space select flag. It is registered one cycle after the operand.

Top module: `regfile_addr_xlate`

## Requirements
- R1: While reset is low and after it is released, both pointers and the page pointer hold 0 and single-window mode is active. `addr_valid`, `phys_addr` and `page_sel` are all 0 until the first operand.
- R2: `addr_valid` is high in exactly the cycle that follows a cycle with `op_valid` high, and `phys_addr`/`page_sel` then hold that operand's result. Operands may arrive back to back. When no operand is presented, `addr_valid` is low and `phys_addr`/`page_sel` hold their last values.
- R3: Command code 1 (set single window) loads pointer 0 with the group `ptr_wdata[7:3]` with its bit 0 cleared, so group 3 behaves as group 2, and clears the mode flag of pointer 0. `ptr_wdata[2:0]` has no effect.
- R4: Command code 2 loads pointer 0 and code 3 loads pointer 1, each with the group `ptr_wdata[7:3]` unrounded, and each sets the mode flag of the pointer it writes. Only the mode flag of pointer 0 selects twin-window mode.
- R5: In single-window mode, working register N (0..15) resolves to pointer-0 base (group × 8) plus N, for example base 70h with r7 gives 77h.
- R6: In twin-window mode, r0..r7 resolve to pointer-0 base plus N, and r8..r15 resolve to pointer-1 base plus (N − 8). For example, a pointer-1 base of 32 with r12 gives 36.
- R7: Command code 4 loads the page pointer with `ptr_wdata[7:2]` (0..63). `ptr_wdata[1:0]` has no effect.
- R8: Any resolved address F0h..FFh gives `page_sel` = 1 and `phys_addr` = `{page, address}`. This holds for direct and for working-register addressing alike.
- R9: A direct address D0h..DFh never reaches group D directly. Its low nibble is resolved as a working-register number under the current pointer mode.
- R10: A direct address in groups 0..C or E gives `page_sel` = 0 and `phys_addr` = `{6'b0, address}`.
- R11: Command codes 5..7 have no effect. A command issued in the same cycle as an operand takes effect only for later operands.

`op_kind` encoding: 0 = working register (number in `op_value[3:0]`), 1 = direct address (`op_value[7:0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ptr_cmd | input | 3 | Pointer command: 0 none, 1 single, 2 twin pointer 0, 3 twin pointer 1, 4 page |
| ptr_wdata | input | 8 | Data for the pointer command |
| op_valid | input | 1 | Operand present this cycle |
| op_kind | input | 1 | 0 working register, 1 direct address |
| op_value | input | 8 | Operand value |
| addr_valid | output | 1 | Result valid (one cycle after op_valid) |
| phys_addr | output | 14 | Physical address {page, register address} |
| page_sel | output | 1 | Result lies in the paged group |

## Verification
Every translated address appears on `phys_addr` and `page_sel` exactly one clock edge after the operand is presented. A pointer command changes the state used by operands from the next edge onward. The bench drives on falling edges: a command in one half-period, the operand at the next falling edge, and the result sampled at the falling edge after that, which is one rising edge later. The same-cycle and back-to-back cases sample at every falling edge, so the old-pointer result and the new-pointer result are each checked in their own cycle.

// File: rtl/rfx_pkg.sv
// Shared widths, command codes and group constants for the register file
// address translator. Assumes an 8-bit register address split into a
// 4-bit group nibble and a 4-bit register nibble.
package rfx_pkg;
    localparam int GRP_W  = 5;               // 8-register group number width
    localparam int WIN_W  = 3;               // log2 of a half window
    localparam int RA_W   = GRP_W + WIN_W;   // register address width
    localparam int WR_W   = WIN_W + 1;       // working register number width
    localparam int HI_W   = RA_W - WR_W;     // group nibble width
    localparam int PAGE_W = 6;               // page number width
    localparam int PA_W   = PAGE_W + RA_W;   // physical address width

    localparam logic [HI_W-1:0] GRP_PAGED = '1;
    localparam logic [HI_W-1:0] GRP_LOCAL = HI_W'(13);

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_SINGLE = 3'd1,
        CMD_TWIN0  = 3'd2,
        CMD_TWIN1  = 3'd3,
        CMD_PAGE   = 3'd4
    } ptr_cmd_e;
endpackage

// File: rtl/rfx_ptr_bank.sv
// Pointer bank: holds two register pointers (group number plus mode flag)
// and the page pointer, and applies set-pointer commands. Assumes command
// codes from rfx_pkg; undefined codes are ignored.
module rfx_ptr_bank
    import rfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [RA_W-1:0]   wdata,
    output logic [GRP_W-1:0]  grp0,
    output logic [GRP_W-1:0]  grp1,
    output logic              twin_mode,
    output logic [PAGE_W-1:0] page
);
    ptr_cmd_e cmd_e;
    assign cmd_e = ptr_cmd_e'(cmd);

    // One pointer per window: {group, mode flag}
    for (genvar i = 0; i < 2; i++) begin : g_ptr
        localparam ptr_cmd_e TWIN_CMD   = (i == 0) ? CMD_TWIN0 : CMD_TWIN1;
        localparam bit       HAS_SINGLE = (i == 0);
        logic [GRP_W:0] ptr_q;

        // Load the pointer on its own set command
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (HAS_SINGLE && cmd_e == CMD_SINGLE)
                ptr_q <= {wdata[RA_W-1:WIN_W+1], 1'b0, 1'b0};
            else if (cmd_e == TWIN_CMD)
                ptr_q <= {wdata[RA_W-1:WIN_W], 1'b1};
        end
    end

    logic [PAGE_W-1:0] page_q;

    // Load the page pointer on the page command
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (cmd_e == CMD_PAGE)
            page_q <= wdata[RA_W-1:RA_W-PAGE_W];
    end

    // Expose stored state
    assign grp0      = g_ptr[0].ptr_q[GRP_W:1];
    assign twin_mode = g_ptr[0].ptr_q[0];
    assign grp1      = g_ptr[1].ptr_q[GRP_W:1];
    assign page      = page_q;

    logic unused_rp1_flag;
    logic unused_wbits;
    assign unused_rp1_flag = g_ptr[1].ptr_q[0];
    assign unused_wbits    = ^wdata[WIN_W-2:0];

    assert_single_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 3'(CMD_SINGLE) |=> !twin_mode && !grp0[0]
            && grp0[GRP_W-1:1] == $past(wdata[RA_W-1:WIN_W+1]));

    assert_twin0_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 3'(CMD_TWIN0) |=> twin_mode && grp0 == $past(wdata[RA_W-1:WIN_W]));

    assert_twin1_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 3'(CMD_TWIN1) |=> grp1 == $past(wdata[RA_W-1:WIN_W])
            && $stable(grp0) && $stable(twin_mode));

    assert_page_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 3'(CMD_PAGE) |=> page == $past(wdata[RA_W-1:RA_W-PAGE_W]));

    assert_bad_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd > 3'(CMD_PAGE) |=> $stable(grp0) && $stable(grp1)
            && $stable(twin_mode) && $stable(page));
endmodule

// File: rtl/rfx_wr_resolve.sv
// Working-register resolver: maps a 4-bit working register number onto
// an 8-bit register address using one 16-register window or two
// 8-register windows. Assumes pointer 0 holds an even group in single mode.
module rfx_wr_resolve
    import rfx_pkg::*;
(
    input  logic [WR_W-1:0]  wr_num,
    input  logic [GRP_W-1:0] grp0,
    input  logic [GRP_W-1:0] grp1,
    input  logic             twin_mode,
    output logic [RA_W-1:0]  ra
);
    // Window bases are aligned, so the offset is a concatenation
    always_comb begin
        if (!twin_mode)
            ra = {grp0[GRP_W-1:1], wr_num};
        else if (!wr_num[WR_W-1])
            ra = {grp0, wr_num[WIN_W-1:0]};
        else
            ra = {grp1, wr_num[WIN_W-1:0]};
    end
endmodule

// File: rtl/rfx_page_map.sv
// Page mapper: qualifies addresses in the top group with the current page
// and flags them as page space; all other addresses pass with page field 0.
module rfx_page_map
    import rfx_pkg::*;
(
    input  logic [RA_W-1:0]   ra,
    input  logic [PAGE_W-1:0] page,
    output logic [PA_W-1:0]   phys,
    output logic              sel
);
    // Decide page space from the group nibble
    always_comb begin
        sel  = (ra[RA_W-1:WR_W] == GRP_PAGED);
        phys = sel ? {page, ra} : {{PAGE_W{1'b0}}, ra};
    end
endmodule

// File: rtl/regfile_addr_xlate.sv
// Register file address translator top: selects working or direct
// resolution (group D direct addresses go through the pointers), applies
// page mapping and registers the result with one cycle of latency.
module regfile_addr_xlate
    import rfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      ptr_cmd,
    input  logic [7:0]      ptr_wdata,
    input  logic            op_valid,
    input  logic            op_kind,
    input  logic [7:0]      op_value,
    output logic            addr_valid,
    output logic [13:0]     phys_addr,
    output logic            page_sel
);
    logic [GRP_W-1:0]  grp0;
    logic [GRP_W-1:0]  grp1;
    logic              twin_mode;
    logic [PAGE_W-1:0] page;
    logic [RA_W-1:0]   ra_wr;
    logic [RA_W-1:0]   ra_sel;
    logic [PA_W-1:0]   phys_d;
    logic              sel_d;
    logic              dir_local;
    logic              use_wr;

    rfx_ptr_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (ptr_cmd),
        .wdata     (ptr_wdata),
        .grp0      (grp0),
        .grp1      (grp1),
        .twin_mode (twin_mode),
        .page      (page)
    );

    rfx_wr_resolve u_wr (
        .wr_num    (op_value[WR_W-1:0]),
        .grp0      (grp0),
        .grp1      (grp1),
        .twin_mode (twin_mode),
        .ra        (ra_wr)
    );

    // Pick working or direct address; group D direct goes via pointers
    always_comb begin
        dir_local = op_kind && (op_value[RA_W-1:WR_W] == GRP_LOCAL);
        use_wr    = !op_kind || dir_local;
        ra_sel    = use_wr ? ra_wr : op_value;
    end

    rfx_page_map u_map (
        .ra   (ra_sel),
        .page (page),
        .phys (phys_d),
        .sel  (sel_d)
    );

    // Output register: one cycle from operand to address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            phys_addr  <= '0;
            page_sel   <= 1'b0;
        end else begin
            addr_valid <= op_valid;
            if (op_valid) begin
                phys_addr <= phys_d;
                page_sel  <= sel_d;
            end
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> addr_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !addr_valid && $stable(phys_addr) && $stable(page_sel));

    assert_paged_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind && op_value[7:4] == GRP_PAGED
        |=> page_sel && phys_addr == {$past(page), $past(op_value)});

    assert_page_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
        page_sel |-> phys_addr[7:4] == GRP_PAGED);

    assert_plain_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind && op_value[7:4] != GRP_PAGED && op_value[7:4] != GRP_LOCAL
        |=> !page_sel && phys_addr == {6'b0, $past(op_value)});

    assert_local_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind && op_value[7:4] == GRP_LOCAL && !twin_mode
        |=> phys_addr[7:0] == {$past(grp0[GRP_W-1:1]), $past(op_value[3:0])});

    assert_twin_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_kind && twin_mode && op_value[3]
        |=> phys_addr[7:3] == $past(grp1));
endmodule

// File: tb/regfile_addr_xlate_bench.sv
`timescale 1ns/1ps
module regfile_addr_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ptr_cmd = '0;
    logic [7:0]  ptr_wdata = '0;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [7:0]  op_value = '0;
    logic        addr_valid;
    logic [13:0] phys_addr;
    logic        page_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    regfile_addr_xlate u_regfile_addr_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_cmd    (ptr_cmd),
        .ptr_wdata  (ptr_wdata),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .op_value   (op_value),
        .addr_valid (addr_valid),
        .phys_addr  (phys_addr),
        .page_sel   (page_sel)
    );

    // {cmd[2:0], wdata[7:0], kind, value[7:0], exp_sel, exp_addr[13:0]}
    localparam int NV = 19;
    localparam logic [34:0] VEC [NV] = '{
        {3'd0, 8'h00, 1'b0, 8'h05, 1'b0, 14'h0005}, // R1 R5 reset base 0
        {3'd1, 8'h38, 1'b0, 8'h07, 1'b0, 14'h0037}, // R3 group 7 -> 6
        {3'd1, 8'h70, 1'b0, 8'h07, 1'b0, 14'h0077}, // R5 base 70h, r7
        {3'd0, 8'h00, 1'b0, 8'h0F, 1'b0, 14'h007F}, // R5 r15
        {3'd2, 8'h60, 1'b0, 8'h05, 1'b0, 14'h0065}, // R4 R6 base 96, r5
        {3'd3, 8'h20, 1'b0, 8'h0C, 1'b0, 14'h0024}, // R4 R6 base 32, r12
        {3'd0, 8'h00, 1'b0, 8'h03, 1'b0, 14'h0063}, // R6 lower window
        {3'd0, 8'h00, 1'b0, 8'h08, 1'b0, 14'h0020}, // R6 r8 edge
        {3'd4, 8'h17, 1'b1, 8'hF2, 1'b1, 14'h05F2}, // R7 R8 page 5
        {3'd0, 8'h00, 1'b1, 8'hE7, 1'b0, 14'h00E7}, // R10 system group
        {3'd0, 8'h00, 1'b1, 8'h00, 1'b0, 14'h0000}, // R10 address 0
        {3'd0, 8'h00, 1'b1, 8'hD3, 1'b0, 14'h0063}, // R9 twin lower
        {3'd0, 8'h00, 1'b1, 8'hDB, 1'b0, 14'h0023}, // R9 twin upper
        {3'd1, 8'hD7, 1'b1, 8'hD4, 1'b0, 14'h00D4}, // R3 R9 low bits ignored
        {3'd4, 8'hFF, 1'b1, 8'hFF, 1'b1, 14'h3FFF}, // R7 R8 page 63
        {3'd1, 8'hF8, 1'b0, 8'h02, 1'b1, 14'h3FF2}, // R8 working into F
        {3'd3, 8'h00, 1'b0, 8'h09, 1'b1, 14'h3FF9}, // R4 rp1 flag no switch
        {3'd2, 8'h48, 1'b0, 8'h09, 1'b0, 14'h0001}, // R4 R6 twin again
        {3'd5, 8'h80, 1'b0, 8'h01, 1'b0, 14'h0049}  // R11 code 5 ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Operand at a falling edge, result checked at the next falling edge
    task automatic do_op(input logic kind, input logic [7:0] val, input string req,
                         input logic exp_sel, input logic [13:0] exp_addr);
        op_valid = 1'b1;
        op_kind  = kind;
        op_value = val;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, {31'd0, addr_valid}, 32'd1);
        check(req, {31'd0, page_sel}, {31'd0, exp_sel});
        check(req, {18'd0, phys_addr}, {18'd0, exp_addr});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1", {17'd0, addr_valid, phys_addr, page_sel}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {17'd0, addr_valid, phys_addr, page_sel}, 32'd0);
        do_op(1'b0, 8'h09, "R1", 1'b0, 14'h0009);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VEC[i];
            ptr_cmd   = v[34:32];
            ptr_wdata = v[31:24];
            @(negedge clk);
            ptr_cmd   = '0;
            ptr_wdata = '0;
            do_op(v[23], v[22:15], $sformatf("vector %0d", i), v[14], v[13:0]);
        end

        // R2 idle: valid low, outputs held
        repeat (3) begin
            @(negedge clk);
            check("R2", {31'd0, addr_valid}, 32'd0);
            check("R2", {17'd0, phys_addr, page_sel}, {17'd0, 14'h0049, 1'b0});
        end

        // R11 command and operand in the same cycle: old pointers used
        ptr_cmd   = 3'd1;
        ptr_wdata = 8'h10;
        do_op(1'b0, 8'h01, "R11", 1'b0, 14'h0049);
        ptr_cmd   = '0;
        ptr_wdata = '0;
        do_op(1'b0, 8'h01, "R11", 1'b0, 14'h0011);

        // R2 back-to-back operands
        op_valid = 1'b1;
        op_kind  = 1'b1;
        op_value = 8'h12;
        @(negedge clk);
        check("R2", {17'd0, addr_valid, phys_addr, page_sel}, {17'd0, 1'b1, 14'h0012, 1'b0});
        op_value = 8'h34;
        @(negedge clk);
        op_valid = 1'b0;
        check("R2", {17'd0, addr_valid, phys_addr, page_sel}, {17'd0, 1'b1, 14'h0034, 1'b0});

        // R1 reset mid-run clears pointers and page
        ptr_cmd   = 3'd4;
        ptr_wdata = 8'hA8;
        @(negedge clk);
        ptr_cmd   = 3'd2;
        ptr_wdata = 8'h90;
        @(negedge clk);
        ptr_cmd   = '0;
        rst_n     = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", {17'd0, addr_valid, phys_addr, page_sel}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        do_op(1'b1, 8'hF0, "R1", 1'b1, 14'h00F0);
        do_op(1'b0, 8'h0F, "R1", 1'b0, 14'h000F);

        summary();
    end
endmodule